// File: doc/BRIEF.md
# Cluster Interrupt Routing Matrix

This block sits between a cluster's interrupt sources and its cores. Every device interrupt input can be routed to any number of output lines through a full enable matrix. The cores are served four output lines each, so core `c` owns lines `4c` to `4c+3`. Each output line keeps its own pending bitmap. An input that is enabled on a line is latched into that line's bitmap while it is high. The line is asserted for as long as its bitmap is not empty.

Software talks to the block through a small memory-mapped port. The port accepts byte writes and returns 64-bit reads. Each output line has a 1 KiB register window. The window holds one enable byte per input, starting at window offset 0. It also holds a 192-bit pending field, split into three 64-bit words starting at window offset 0x120. Reading a pending word returns its bits and clears them in the same access. An interrupt service routine therefore reads the words of its line and handles every set bit, with no separate acknowledge step.

The per-input index space is 157 entries wide. Only `NUM_INPUTS` inputs are implemented, 139 on the cluster. The number of cores is a parameter: the cluster sets 18, and the default is kept small.

Top module: `irq_route_matrix`

## Requirements
- R1: After reset all enable bits are 0, all pending bits are clear, every output line is low and `bus_ready` is low.
- R2: A byte write to offset `n` (with `n` < `NUM_INPUTS`) of line `k`'s window stores bit 0 of the written byte as the enable of input `n` on line `k`. A read of that offset returns the enable in bit 0, with bits 63:1 zero.
- R3: When input `n` is high at a clock edge and its enable on line `k` is 1, pending bit `n` of line `k` is set at that edge. Output line `k` is high from that edge onward.
- R4: An input whose enable on a line is 0 never sets that line's pending bit.
- R5: The status word `w` (0 to 2) of a line sits at window offset 0x120 + 8·`w`. Bit `b` of that word is the pending bit of input 64·`w`+`b`. A read returns the word and clears exactly the returned bits, so an immediate second read returns zero.
- R6: If a pending bit is set and cleared by a status read in the same cycle, the set wins and the bit stays 1.
- R7: An input enabled on several lines is captured in each of them independently. Reading one line's status does not clear another line's bits.
- R8: Each output line is the OR of its own pending bits. It stays high until a status read empties its field, and it is low in the cycle after that read.
- R9: Pending bits at index `NUM_INPUTS` and above always read as zero. Writes to any other offset are ignored, and reads of it return zero. This covers enable offsets at or above `NUM_INPUTS`, misaligned status offsets and the rest of the window.
- R10: Each access gets `bus_ready` high in the following cycle, with read data valid in that same cycle. `bus_ready` is low after an idle cycle, and `bus_rdata` is zero when no read was made.
- R11: The window of line `k` starts at byte address `k`·0x400, so core `c`'s group of four starts at `c`·0x1000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_INPUTS | Device interrupt inputs, level sampled every cycle |
| bus_addr | input | ADDR_W | Byte address: line index above bit 10, window offset in bits 9:0 |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write byte; bit 0 is stored for enable entries |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 64 | Read data, valid with `bus_ready` |
| bus_ready | output | 1 | Access completion, one cycle after the strobe |
| irq_line | output | NUM_CORES*4 | Output interrupt lines, line `4c+j` belongs to core `c` |

## Verification
The assertions assume that each read or write strobe stands for one access lasting one cycle. They also assume that `irq_in` is the only thing that can raise an output line. An edge on a line with no input high one cycle earlier would therefore be flagged. The stimulus changes inputs and strobes only on the falling clock edge, and it holds each strobe for exactly one cycle. It raises interrupt inputs only for lines whose enables it has set itself. The sweep covers every input on every line of a four-line, 20-input configuration. This makes the out-of-range index, status word and window cases reachable with few inputs.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int WIN_SHIFT       = 10;      // 0x400-byte window per line
    localparam int LINES_PER_CORE  = 4;
    localparam int STATUS_BASE     = 'h120;
    localparam int STAT_WORD_BYTES = 8;
    localparam int WORD_BITS       = 64;

    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_ENABLE = 2'd1,
        ACC_STATUS = 2'd2
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e   kind;
        logic [7:0]  in_idx;
        logic [1:0]  word_idx;
    } acc_decode_t;

    function automatic int status_words(input int slots);
        return (slots + WORD_BITS - 1) / WORD_BITS;
    endfunction

    function automatic int line_bits(input int lines);
        return (lines > 1) ? $clog2(lines) : 1;
    endfunction

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import irq_router_pkg::*;
#(
    parameter int NUM_LINES   = 8,
    parameter int NUM_INPUTS  = 139,
    parameter int INPUT_SLOTS = 157,
    localparam int LINE_W     = line_bits(NUM_LINES),
    localparam int ADDR_W     = WIN_SHIFT + LINE_W
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_decode_t       dec,
    output logic [LINE_W-1:0] line_idx,
    output logic              line_ok
);
    localparam int SW = status_words(INPUT_SLOTS);
    localparam logic [9:0] STAT_LO = 10'(STATUS_BASE);
    localparam logic [9:0] STAT_HI = 10'(STATUS_BASE + STAT_WORD_BYTES * SW);

    logic [9:0] off;
    logic [9:0] rel;

    always_comb begin
        off          = addr[WIN_SHIFT-1:0];
        line_idx     = addr[ADDR_W-1:WIN_SHIFT];
        line_ok      = (32'(line_idx) < NUM_LINES);
        rel          = off - STAT_LO;
        dec.kind     = ACC_NONE;
        dec.in_idx   = off[7:0];
        dec.word_idx = rel[4:3];
        if (line_ok) begin
            if (off < 10'(NUM_INPUTS))
                dec.kind = ACC_ENABLE;
            else if (off >= STAT_LO && off < STAT_HI && off[2:0] == 3'b000)
                dec.kind = ACC_STATUS;
        end
    end
endmodule

// File: rtl/irq_line_slice.sv
module irq_line_slice
    import irq_router_pkg::*;
#(
    parameter int NUM_INPUTS  = 139,
    parameter int INPUT_SLOTS = 157
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_INPUTS-1:0] irq_in,
    input  logic                  sel,
    input  acc_decode_t           dec,
    input  logic                  wr_en,
    input  logic                  wr_bit,
    input  logic                  rd_en,
    output logic [63:0]           rd_word,
    output logic                  line_irq
);
    localparam int SW      = status_words(INPUT_SLOTS);
    localparam int FIELD_W = SW * WORD_BITS;
    localparam int IDX_W   = (NUM_INPUTS > 1) ? $clog2(NUM_INPUTS) : 1;

    logic [NUM_INPUTS-1:0] en_q, pend_q, pend_d, clr;
    logic [FIELD_W-1:0]    field, clr_field;
    logic [IDX_W-1:0]      idx;
    logic                  unused_idx;

    assign idx        = dec.in_idx[IDX_W-1:0];
    assign unused_idx = ^dec.in_idx;

    always_comb begin
        field                   = '0;
        field[NUM_INPUTS-1:0]   = pend_q;
        clr_field               = '0;
        if (sel && rd_en && dec.kind == ACC_STATUS)
            clr_field[int'(dec.word_idx)*WORD_BITS +: WORD_BITS] = '1;
        clr    = clr_field[NUM_INPUTS-1:0];
        // a new capture in the same cycle overrides the read clear
        pend_d = (pend_q & ~clr) | (irq_in & en_q);
    end

    always_comb begin
        rd_word = '0;
        if (sel) begin
            case (dec.kind)
                ACC_ENABLE: rd_word = {63'd0, en_q[idx]};
                ACC_STATUS: rd_word = field[int'(dec.word_idx)*WORD_BITS +: WORD_BITS];
                default:    rd_word = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
            if (sel && wr_en && dec.kind == ACC_ENABLE)
                en_q[idx] <= wr_bit;
        end
    end

    assign line_irq = |pend_q;
endmodule

// File: rtl/irq_route_matrix.sv
module irq_route_matrix
    import irq_router_pkg::*;
#(
    parameter int NUM_CORES   = 2,
    parameter int NUM_INPUTS  = 139,
    parameter int INPUT_SLOTS = 157,
    localparam int NUM_LINES  = NUM_CORES * LINES_PER_CORE,
    localparam int LINE_W     = line_bits(NUM_LINES),
    localparam int ADDR_W     = WIN_SHIFT + LINE_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_INPUTS-1:0] irq_in,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic [7:0]            bus_wdata,
    input  logic                  bus_rd,
    output logic [63:0]           bus_rdata,
    output logic                  bus_ready,
    output logic [NUM_LINES-1:0]  irq_line
);
    acc_decode_t       dec;
    logic [LINE_W-1:0] line_idx;
    logic              line_ok;
    logic [63:0]       line_word [NUM_LINES];
    logic [63:0]       rd_mux;
    logic              unused_wdata;

    assign unused_wdata = ^bus_wdata[7:1];

    irq_reg_decode #(
        .NUM_LINES  (NUM_LINES),
        .NUM_INPUTS (NUM_INPUTS),
        .INPUT_SLOTS(INPUT_SLOTS)
    ) i_decode (
        .addr    (bus_addr),
        .dec     (dec),
        .line_idx(line_idx),
        .line_ok (line_ok)
    );

    for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
        logic sel;
        assign sel = line_ok && (32'(line_idx) == k);

        irq_line_slice #(
            .NUM_INPUTS (NUM_INPUTS),
            .INPUT_SLOTS(INPUT_SLOTS)
        ) i_slice (
            .clk     (clk),
            .rst     (rst),
            .irq_in  (irq_in),
            .sel     (sel),
            .dec     (dec),
            .wr_en   (bus_wr),
            .wr_bit  (bus_wdata[0]),
            .rd_en   (bus_rd),
            .rd_word (line_word[k]),
            .line_irq(irq_line[k])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int k = 0; k < NUM_LINES; k++)
            rd_mux = rd_mux | line_word[k];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_ready <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_ready <= bus_wr | bus_rd;
            bus_rdata <= bus_rd ? rd_mux : 64'd0;
        end
    end
endmodule

// File: rtl/irq_route_matrix_chk.sv
module irq_route_matrix_chk
    import irq_router_pkg::*;
#(
    parameter int NUM_LINES  = 8,
    parameter int NUM_INPUTS = 139
) (
    input logic                  clk,
    input logic                  rst,
    input logic [NUM_INPUTS-1:0] irq_in,
    input logic                  bus_wr,
    input logic                  bus_rd,
    input logic [63:0]           bus_rdata,
    input logic                  bus_ready,
    input logic [NUM_LINES-1:0]  irq_line,
    input acc_kind_e             acc_kind
);
    p_ready_after_access_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_wr || bus_rd) |=> bus_ready);

    p_ready_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr || bus_rd) |=> !bus_ready);

    p_no_read_no_data_r10: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> bus_rdata == 64'd0);

    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && acc_kind == ACC_NONE) |=> bus_rdata == 64'd0);

    p_enable_bit0_only_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && acc_kind == ACC_ENABLE) |=> bus_rdata[63:1] == 63'd0);

    for (genvar k = 0; k < NUM_LINES; k++) begin : g_line_chk
        p_rise_needs_input_r3: assert property (@(posedge clk) disable iff (rst)
            $rose(irq_line[k]) |-> $past(|irq_in));

        p_hold_until_read_r8: assert property (@(posedge clk) disable iff (rst)
            (irq_line[k] && !bus_rd) |=> irq_line[k]);
    end
endmodule

bind irq_route_matrix irq_route_matrix_chk #(
    .NUM_LINES (NUM_LINES),
    .NUM_INPUTS(NUM_INPUTS)
) i_chk (
    .clk      (clk),
    .rst      (rst),
    .irq_in   (irq_in),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_rdata(bus_rdata),
    .bus_ready(bus_ready),
    .irq_line (irq_line),
    .acc_kind (dec.kind)
);

// File: tb/test_irq_route_matrix.sv
module test_irq_route_matrix;
    localparam int CLK_PERIOD = 10;
    localparam int NC   = 1;
    localparam int NI   = 20;
    localparam int NL   = NC * 4;
    localparam int AW   = 12;
    localparam int STAT = 'h120;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NI-1:0] irq_in = '0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_wdata = '0;
    logic          bus_rd = 1'b0;
    logic [63:0]   bus_rdata;
    logic          bus_ready;
    logic [NL-1:0] irq_line;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_route_matrix #(.NUM_CORES(NC), .NUM_INPUTS(NI), .INPUT_SLOTS(157)) i_irq_route_matrix (
        .clk(clk), .rst(rst), .irq_in(irq_in), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .irq_line(irq_line)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] adr(input int line, input int off);
        return AW'(line * 'h400 + off);
    endfunction

    task automatic wr(input int line, input int off, input logic [7:0] val);
        bus_addr = adr(line, off); bus_wdata = val; bus_wr = 1'b1;
        @(negedge clk);
        chk("R10 write ready", 64'(bus_ready), 64'd1);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int line, input int off, output logic [63:0] data);
        bus_addr = adr(line, off); bus_rd = 1'b1;
        @(negedge clk);
        chk("R10 read ready", 64'(bus_ready), 64'd1);
        data = bus_rdata;
        bus_rd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 lines low", 64'(irq_line), 64'd0);
        chk("R1 ready low", 64'(bus_ready), 64'd0);
        for (int k = 0; k < NL; k++) begin
            for (int w = 0; w < 3; w++) begin
                rd(k, STAT + 8*w, d); chk("R1 status clear", d, 64'd0);
            end
            for (int n = 0; n < NI; n++) begin
                rd(k, n, d); chk("R1 enable zero", d, 64'd0);
            end
        end
        @(negedge clk);
        chk("R10 idle ready low", 64'(bus_ready), 64'd0);
        chk("R10 idle data zero", bus_rdata, 64'd0);

        // R2 enable storage, bit 0 only
        wr(2, 7, 8'hFF); rd(2, 7, d); chk("R2 enable set", d, 64'd1);
        wr(2, 7, 8'hFE); rd(2, 7, d); chk("R2 enable bit0 only", d, 64'd0);

        // R3 R5 R7 R8 R11 sweep: each input on each line alone
        for (int k = 0; k < NL; k++) begin
            for (int n = 0; n < NI; n++) begin
                wr(k, n, 8'h01);
                irq_in = NI'(1) << n;
                @(negedge clk);
                irq_in = '0;
                chk("R3 line asserted", 64'(irq_line), 64'(1) << k);
                for (int j = 0; j < NL; j++) begin
                    rd(j, STAT, d);
                    chk("R5 R11 status word0", d, (j == k) ? (64'd1 << n) : 64'd0);
                end
                chk("R8 line drops after read", 64'(irq_line), 64'd0);
                rd(k, STAT, d); chk("R5 second read empty", d, 64'd0);
                wr(k, n, 8'h00);
            end
        end

        // R4 disabled inputs not captured
        irq_in = '1;
        repeat (3) @(negedge clk);
        irq_in = '0;
        chk("R4 lines stay low", 64'(irq_line), 64'd0);
        rd(1, STAT, d); chk("R4 status empty", d, 64'd0);

        // R7 one input on two lines
        wr(0, 5, 8'h01); wr(3, 5, 8'h01);
        irq_in = NI'(1) << 5;
        @(negedge clk);
        irq_in = '0;
        chk("R7 both lines", 64'(irq_line), 64'b1001);
        rd(0, STAT, d); chk("R7 line0 bit", d, 64'd1 << 5);
        chk("R7 line3 kept", 64'(irq_line), 64'b1000);
        rd(3, STAT, d); chk("R7 line3 bit", d, 64'd1 << 5);
        wr(0, 5, 8'h00); wr(3, 5, 8'h00);

        // R6 set wins over clear
        wr(1, 3, 8'h01);
        irq_in = NI'(1) << 3;
        @(negedge clk);
        rd(1, STAT, d); chk("R6 first read", d, 64'd1 << 3);
        irq_in = '0;
        chk("R6 line still high", 64'(irq_line), 64'b0010);
        rd(1, STAT, d); chk("R6 bit kept by set", d, 64'd1 << 3);
        rd(1, STAT, d); chk("R6 then cleared", d, 64'd0);
        chk("R8 line low", 64'(irq_line), 64'd0);
        wr(1, 3, 8'h00);

        // R9 out-of-range indexes and unmapped offsets
        for (int n = 0; n < NI; n++) wr(2, n, 8'h01);
        wr(2, 25, 8'h01); rd(2, 25, d); chk("R9 enable beyond inputs", d, 64'd0);
        irq_in = '1;
        @(negedge clk);
        rd(2, STAT + 8, d);  chk("R9 word1 zero", d, 64'd0);
        rd(2, STAT + 16, d); chk("R9 word2 zero", d, 64'd0);
        rd(2, STAT + 1, d);  chk("R9 misaligned zero", d, 64'd0);
        rd(2, 'h200, d);     chk("R9 unmapped zero", d, 64'd0);
        wr(2, 'h200, 8'hFF);
        rd(2, STAT, d);      chk("R9 word0 upper zero", d, 64'hF_FFFF);
        irq_in = '0;
        @(negedge clk);
        rd(2, STAT, d);      chk("R6 R9 last capture", d, 64'hF_FFFF);
        rd(2, STAT, d);      chk("R5 emptied", d, 64'd0);
        chk("R8 line low at end", 64'(irq_line), 64'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule